// File: doc/BRIEF.md
# Multifunction Register with Command Conflicts

A small clocked storage register that can keep its value, take a new value from its parallel data input, count up by one, or return to zero. Its output shows the stored value at all times. The clock reaches the flip-flops directly; every choice of behaviour is made in the next-state logic.

By default the register is steered by three independent command strobes: load, increment and clear. Exactly one strobe asserted picks that operation. Any overlap of two or three strobes is treated as a conflict, and the register keeps its value; no strobe has priority over another. A build-time variant replaces the strobes with a 2-bit encoded operation select. A synchronous active-high reset clears the register for start-up.

Top module: `mfreg`

## Requirements
- R1: While `rst` is high at a rising clock edge, the stored value becomes 0 whatever the other inputs are.
- R2: In strobe mode (`SEL_MODE`=0), with none of `load_i`, `inc_i`, `clr_i` high, the stored value is kept.
- R3: In strobe mode, `load_i` alone copies `din` into the register at the edge.
- R4: In strobe mode, `inc_i` alone adds one to the stored value; 15 wraps to 0.
- R5: In strobe mode, `clr_i` alone sets the stored value to 0.
- R6: In strobe mode, any two or all three strobes high together leave the stored value unchanged.
- R7: In select mode (`SEL_MODE`=1), `mode_sel` 2'b00 keeps, 2'b01 loads `din`, 2'b10 adds one with wrap, 2'b11 clears; the three strobes have no effect.
- R8: In strobe mode, `mode_sel` has no effect on the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, fed straight to the flip-flops |
| rst | input | 1 | Synchronous active-high clear |
| load_i | input | 1 | Load strobe (strobe mode) |
| inc_i | input | 1 | Increment strobe (strobe mode) |
| clr_i | input | 1 | Clear strobe (strobe mode) |
| mode_sel | input | 2 | Encoded operation (select mode) |
| din | input | W | Parallel data to load |
| dout | output | W | Stored value |

## Verification
Because `dout` is the register itself, a wrong next-state decision shows at the ports one clock edge after the offending command, with no latency to hide it. A priority leaking into the conflict decode shows as a value change in a cycle that should have held, and a wrong increment width shows at the 15-to-0 wrap. Ignored inputs are toggled while the register is expected to hold, so any effect they have appears on the very next edge.

// File: rtl/mfreg.sv
module mfreg #(
  parameter int W = 4,
  parameter bit SEL_MODE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         inc_i,
  input  logic         clr_i,
  input  logic [1:0]   mode_sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  typedef enum logic [1:0] {OP_HOLD = 2'b00, OP_LOAD = 2'b01, OP_INC = 2'b10, OP_CLR = 2'b11} op_t;

  op_t          op;
  logic [W-1:0] q, nxt;

  generate
    if (SEL_MODE) begin : g_sel
      assign op = op_t'(mode_sel);

      assert_sel_load_R7: assert property (@(posedge clk) disable iff (rst)
        mode_sel == 2'b01 |=> q == $past(din));
      assert_sel_inc_R7: assert property (@(posedge clk) disable iff (rst)
        mode_sel == 2'b10 |=> q == W'($past(q) + 1'b1));
      assert_sel_clr_R7: assert property (@(posedge clk) disable iff (rst)
        mode_sel == 2'b11 |=> q == '0);
      assert_sel_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00 && (load_i || inc_i || clr_i)) |=> q == $past(q));
    end else begin : g_cmd
      always_comb begin
        case ({load_i, inc_i, clr_i})
          3'b100:  op = OP_LOAD;
          3'b010:  op = OP_INC;
          3'b001:  op = OP_CLR;
          default: op = OP_HOLD;
        endcase
      end

      assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        {load_i, inc_i, clr_i} == 3'b000 |=> q == $past(q));
      assert_load_R3: assert property (@(posedge clk) disable iff (rst)
        {load_i, inc_i, clr_i} == 3'b100 |=> q == $past(din));
      assert_inc_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        {load_i, inc_i, clr_i} == 3'b010 |=> q == W'($past(q) + 1'b1));
      assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        {load_i, inc_i, clr_i} == 3'b001 |=> q == '0);
      assert_conflict_hold_R6: assert property (@(posedge clk) disable iff (rst)
        $countones({load_i, inc_i, clr_i}) > 1 |=> $stable(q));
      assert_sel_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        ({load_i, inc_i, clr_i} == 3'b000 && mode_sel != 2'b00) |=> q == $past(q));
    end
  endgenerate

  always_comb begin
    case (op)
      OP_LOAD: nxt = din;
      OP_INC:  nxt = q + 1'b1;
      OP_CLR:  nxt = '0;
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign dout = q;

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> q == '0);

endmodule

// File: tb/mfreg_tb.sv
module mfreg_tb;
  localparam int CLK_P = 10;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_i = 1'b0, inc_i = 1'b0, clr_i = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [3:0] din = 4'd0;
  logic [3:0] dout_c, dout_s;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  mfreg #(.W(4), .SEL_MODE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .load_i(load_i), .inc_i(inc_i), .clr_i(clr_i),
    .mode_sel(mode_sel), .din(din), .dout(dout_c));

  mfreg #(.W(4), .SEL_MODE(1'b1)) u_dut_sel (
    .clk(clk), .rst(rst), .load_i(load_i), .inc_i(inc_i), .clr_i(clr_i),
    .mode_sel(mode_sel), .din(din), .dout(dout_s));

  // {tag, load, inc, clr, sel, din, expected} for the strobe-mode register
  localparam logic [16:0] VEC [NV] = '{
    {4'd3, 3'b100, 2'b00, 4'd9,  4'd9},   // R3 load
    {4'd8, 3'b000, 2'b11, 4'd2,  4'd9},   // R8 sel ignored
    {4'd4, 3'b010, 2'b00, 4'd0,  4'd10},  // R4 inc
    {4'd6, 3'b110, 2'b00, 4'd3,  4'd10},  // R6 load+inc
    {4'd6, 3'b101, 2'b00, 4'd3,  4'd10},  // R6 load+clr
    {4'd6, 3'b011, 2'b00, 4'd3,  4'd10},  // R6 inc+clr
    {4'd6, 3'b111, 2'b00, 4'd3,  4'd10},  // R6 all three
    {4'd5, 3'b001, 2'b00, 4'd6,  4'd0},   // R5 clear
    {4'd3, 3'b100, 2'b00, 4'd15, 4'd15},  // R3 load max
    {4'd4, 3'b010, 2'b00, 4'd0,  4'd0},   // R4 wrap 15->0
    {4'd4, 3'b010, 2'b00, 4'd0,  4'd1},   // R4 inc
    {4'd8, 3'b000, 2'b01, 4'd7,  4'd1},   // R8 sel ignored
    {4'd3, 3'b100, 2'b10, 4'd5,  4'd5},   // R3 load
    {4'd2, 3'b000, 2'b00, 4'd12, 4'd5}    // R2 idle hold
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic l, input logic i, input logic c, input logic [1:0] s, input logic [3:0] d);
    @(negedge clk);
    load_i = l; inc_i = i; clr_i = c; mode_sel = s; din = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P*5000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset with commands active
    load_i = 1'b1; din = 4'd7; mode_sel = 2'b01;
    @(posedge clk); #1;
    check("R1 strobe reset", dout_c, 4'd0);
    check("R1 select reset", dout_s, 4'd0);
    @(negedge clk);
    rst = 1'b0; load_i = 1'b0; mode_sel = 2'b00;

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][12], VEC[k][11], VEC[k][10], VEC[k][9:8], VEC[k][7:4]);
      check($sformatf("R%0d vector %0d", VEC[k][16:13], k), dout_c, VEC[k][3:0]);
    end

    // R1: reset mid-run overrides a load
    @(negedge clk); rst = 1'b1; load_i = 1'b1; din = 4'd11;
    @(posedge clk); #1;
    check("R1 mid-run reset", dout_c, 4'd0);
    @(negedge clk); rst = 1'b0; load_i = 1'b0;

    // R7: select-mode register, strobes must not matter
    step(1'b0, 1'b0, 1'b1, 2'b01, 4'd12);
    check("R7 sel load", dout_s, 4'd12);
    step(1'b1, 1'b0, 1'b1, 2'b00, 4'd3);
    check("R7 sel hold, strobes ignored", dout_s, 4'd12);
    step(1'b1, 1'b0, 1'b0, 2'b10, 4'd3);
    check("R7 sel inc", dout_s, 4'd13);
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd3);
    check("R7 sel clear", dout_s, 4'd0);
    step(1'b0, 1'b0, 1'b0, 2'b01, 4'd15);
    check("R7 sel load max", dout_s, 4'd15);
    step(1'b0, 1'b0, 1'b1, 2'b10, 4'd0);
    check("R7 sel wrap", dout_s, 4'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule